// File: doc/BRIEF.md
# Warm-up Stability Window Qualifier

This block decides when a reference clock has warmed up enough to be trusted. It receives signed fractional frequency-error samples after power-on or after a thermal disturbance. A one-minute tick paces it. The block moves through three phases in a fixed order: transient, settling and qualified.

Three programmable limits govern it: an error window, a per-minute drift limit and a soak length in minutes. The block reaches the qualified phase only when all three conditions have held together. Any violation sends it back to settling and restarts the soak. The block also latches how many minutes passed before the error first fell inside the window.

A one-cycle learn enable is raised only for in-window samples accepted while qualified. A downstream long-term drift estimator therefore never sees warm-up drift. The sample input is a valid/ready stream. Ready is low only in a cycle where restart is asserted, so a sample offered in that cycle waits. In every other cycle a valid sample is consumed at once, and no back-pressure builds.

Top module: `warmup_qualifier`

## Requirements
- R1: After reset the phase is transient (code 0), and qualified, ttw_valid and learn_en are low.
- R2: smp_ready is low exactly in cycles where restart is high. A sample is accepted when smp_valid and smp_ready are both high.
- R3: The block counts minute ticks from restart. At the first accepted sample with |error| <= win_lim, it latches that count into ttw_minutes and raises ttw_valid. Both then hold until the next restart, whatever later samples do.
- R4: The minute count saturates at 2^TTW_W-1 and does not wrap.
- R5: The block leaves transient for settling (code 1) at a tick where the drift check passes. It never goes from transient straight to qualified (code 2). The drift is |sample at this tick - sample at previous tick|, and it passes when this is <= rate_lim. A tick sample is the sample accepted in that cycle, or else the latest one.
- R6: In settling, each tick whose sample is in the window and passes the drift check adds one soak minute. The phase becomes qualified when the soak count reaches soak_min.
- R7: Outside transient, the phase goes to settling and the soak count clears on either of two events. One is an accepted out-of-window sample. The other is a tick that fails the window or drift check. The latched ttw_minutes is kept.
- R8: learn_en pulses for one cycle after an accepted in-window sample, and only if the phase was qualified when that sample arrived.
- R9: Suppose idle_lim is non-zero and idle_lim consecutive ticks pass with no accepted sample. At that tick the phase drops from settling or qualified to settling, and the soak count clears.
- R10: A restart pulse returns the block to transient and clears ttw_valid, the soak count and the drift history, from any phase.
- R11: The drift difference is formed one bit wider than the samples. Opposite full-scale samples therefore give a large drift and do not wrap to a small one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| restart | input | 1 | Power-on or disturbance marker, one-cycle pulse |
| minute_tick | input | 1 | One-minute pacing strobe |
| smp_valid | input | 1 | Error sample valid |
| smp_ready | output | 1 | Error sample ready |
| smp_err | input | ERR_W | Signed fractional frequency error |
| win_lim | input | ERR_W | Window limit on error magnitude |
| rate_lim | input | ERR_W | Per-minute drift limit |
| soak_min | input | SOAK_W | Soak length in minutes |
| idle_lim | input | IDLE_W | Ticks without a sample before dequalifying, 0 disables |
| phase | output | 2 | 0 transient, 1 settling, 2 qualified |
| qualified | output | 1 | High in the qualified phase |
| ttw_valid | output | 1 | Time-to-window latched |
| ttw_minutes | output | TTW_W | Minutes from restart to first in-window sample |
| learn_en | output | 1 | One-cycle update enable for a slow estimator |

## Verification
Suppose the soak count or the stored previous-tick sample is corrupted. Then qualified rises a tick too early or too late, or fails to drop on a drift jump, and this is seen on the phase port one cycle after that minute tick. A corrupted minute count shows up as a wrong ttw_minutes value in the cycle after the first in-window sample. A stale idle count is seen as a qualified flag that outlives, or never reaches, the idle_lim-th empty tick. A learn_en that fires outside qualification is visible in the cycle after the offending sample.

// File: rtl/wq_pkg.sv
package wq_pkg;
  typedef enum logic [1:0] {
    PH_TRANSIENT = 2'd0,
    PH_SETTLING  = 2'd1,
    PH_QUALIFIED = 2'd2
  } wq_phase_e;
endpackage

// File: rtl/wq_sample_eval.sv
// Sample capture, window test and per-minute drift test.
module wq_sample_eval #(
  parameter int ERR_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    restart,
  input  logic                    minute_tick,
  input  logic                    smp_valid,
  input  logic signed [ERR_W-1:0] smp_err,
  input  logic [ERR_W-1:0]        win_lim,
  input  logic [ERR_W-1:0]        rate_lim,
  output logic                    accept,
  output logic                    acc_in_win,
  output logic                    tick_eval,
  output logic                    tick_pass,
  output logic                    tick_slope_ok
);
  localparam int DW = ERR_W + 1;

  logic signed [ERR_W-1:0] last_q, prev_q, cur;
  logic                    have_q, prev_ok_q;
  logic signed [DW-1:0]    diff;
  logic [DW-1:0]           slope;
  logic [ERR_W-1:0]        smp_mag, cur_mag;

  function automatic logic [ERR_W-1:0] magnitude(input logic signed [ERR_W-1:0] v);
    magnitude = v[ERR_W-1] ? ((~v) + {{(ERR_W-1){1'b0}}, 1'b1}) : v;
  endfunction

  assign accept  = smp_valid && !restart;
  assign cur     = accept ? smp_err : last_q;
  assign smp_mag = magnitude(smp_err);
  assign cur_mag = magnitude(cur);

  // R11: widened difference so opposite full-scale values cannot wrap
  assign diff  = {cur[ERR_W-1], cur} - {prev_q[ERR_W-1], prev_q};
  assign slope = diff[DW-1] ? ((~diff) + {{(DW-1){1'b0}}, 1'b1}) : diff;

  assign acc_in_win    = accept && (smp_mag <= win_lim);
  assign tick_slope_ok = prev_ok_q && (slope <= {1'b0, rate_lim});
  assign tick_eval     = minute_tick && !restart && (have_q || accept);
  assign tick_pass     = (cur_mag <= win_lim) && tick_slope_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q    <= '0;
      prev_q    <= '0;
      have_q    <= 1'b0;
      prev_ok_q <= 1'b0;
    end else if (restart) begin
      have_q    <= 1'b0;
      prev_ok_q <= 1'b0;
    end else begin
      if (accept) begin
        last_q <= smp_err;
        have_q <= 1'b1;
      end
      if (tick_eval) begin
        prev_q    <= cur;
        prev_ok_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wq_phase_ctl.sv
// Phase sequencing, soak counting, idle supervision and learn strobe.
module wq_phase_ctl
  import wq_pkg::*;
#(
  parameter int SOAK_W = 8,
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              minute_tick,
  input  logic              accept,
  input  logic              acc_in_win,
  input  logic              tick_eval,
  input  logic              tick_pass,
  input  logic              tick_slope_ok,
  input  logic [SOAK_W-1:0] soak_min,
  input  logic [IDLE_W-1:0] idle_lim,
  output wq_phase_e         phase,
  output logic              learn_en
);
  localparam logic [SOAK_W-1:0] SOAK_MAX = {SOAK_W{1'b1}};
  localparam logic [IDLE_W-1:0] IDLE_MAX = {IDLE_W{1'b1}};

  wq_phase_e         phase_q, phase_d;
  logic [SOAK_W-1:0] soak_q, soak_d, soak_inc;
  logic [IDLE_W-1:0] idle_q, idle_d, idle_inc;
  logic              starve, learn_q, learn_d;

  assign soak_inc = (soak_q == SOAK_MAX) ? soak_q : soak_q + 1'b1;
  assign idle_inc = (idle_q == IDLE_MAX) ? idle_q : idle_q + 1'b1;
  assign starve   = minute_tick && !accept && (idle_lim != '0) && (idle_inc >= idle_lim);

  always_comb begin
    phase_d = phase_q;
    soak_d  = soak_q;
    idle_d  = idle_q;
    learn_d = acc_in_win && (phase_q == PH_QUALIFIED);

    if (accept)           idle_d = '0;
    else if (minute_tick) idle_d = idle_inc;

    unique case (phase_q)
      PH_TRANSIENT: begin
        if (tick_eval && tick_slope_ok) phase_d = PH_SETTLING;
      end
      default: begin
        if ((accept && !acc_in_win) || starve) begin
          phase_d = PH_SETTLING;
          soak_d  = '0;
        end else if (tick_eval) begin
          if (tick_pass) begin
            soak_d = soak_inc;
            if (soak_inc >= soak_min) phase_d = PH_QUALIFIED;
          end else begin
            phase_d = PH_SETTLING;
            soak_d  = '0;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_TRANSIENT;
      soak_q  <= '0;
      idle_q  <= '0;
      learn_q <= 1'b0;
    end else if (restart) begin
      phase_q <= PH_TRANSIENT;
      soak_q  <= '0;
      idle_q  <= '0;
      learn_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      soak_q  <= soak_d;
      idle_q  <= idle_d;
      learn_q <= learn_d;
    end
  end

  assign phase    = phase_q;
  assign learn_en = learn_q;
endmodule

// File: rtl/wq_ttw.sv
// Minute count since restart and latched time-to-window.
module wq_ttw #(
  parameter int TTW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             minute_tick,
  input  logic             acc_in_win,
  output logic [TTW_W-1:0] ttw_minutes,
  output logic             ttw_valid
);
  localparam logic [TTW_W-1:0] TTW_MAX = {TTW_W{1'b1}};

  logic [TTW_W-1:0] elapsed_q, ttw_q;
  logic             valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_q <= '0;
      ttw_q     <= '0;
      valid_q   <= 1'b0;
    end else if (restart) begin
      elapsed_q <= '0;
      ttw_q     <= '0;
      valid_q   <= 1'b0;
    end else begin
      if (minute_tick && elapsed_q != TTW_MAX) elapsed_q <= elapsed_q + 1'b1;
      if (!valid_q && acc_in_win) begin
        ttw_q   <= elapsed_q;
        valid_q <= 1'b1;
      end
    end
  end

  assign ttw_minutes = ttw_q;
  assign ttw_valid   = valid_q;
endmodule

// File: rtl/warmup_qualifier.sv
module warmup_qualifier
  import wq_pkg::*;
#(
  parameter int ERR_W  = 16,
  parameter int TTW_W  = 10,
  parameter int SOAK_W = 8,
  parameter int IDLE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    restart,
  input  logic                    minute_tick,
  input  logic                    smp_valid,
  output logic                    smp_ready,
  input  logic signed [ERR_W-1:0] smp_err,
  input  logic [ERR_W-1:0]        win_lim,
  input  logic [ERR_W-1:0]        rate_lim,
  input  logic [SOAK_W-1:0]       soak_min,
  input  logic [IDLE_W-1:0]       idle_lim,
  output logic [1:0]              phase,
  output logic                    qualified,
  output logic                    ttw_valid,
  output logic [TTW_W-1:0]        ttw_minutes,
  output logic                    learn_en
);
  logic      accept, acc_in_win, tick_eval, tick_pass, tick_slope_ok;
  wq_phase_e phase_st;

  assign smp_ready = !restart;

  wq_sample_eval #(.ERR_W(ERR_W)) u_eval (
    .clk           (clk),
    .rst_n         (rst_n),
    .restart       (restart),
    .minute_tick   (minute_tick),
    .smp_valid     (smp_valid),
    .smp_err       (smp_err),
    .win_lim       (win_lim),
    .rate_lim      (rate_lim),
    .accept        (accept),
    .acc_in_win    (acc_in_win),
    .tick_eval     (tick_eval),
    .tick_pass     (tick_pass),
    .tick_slope_ok (tick_slope_ok)
  );

  wq_phase_ctl #(.SOAK_W(SOAK_W), .IDLE_W(IDLE_W)) u_phase (
    .clk           (clk),
    .rst_n         (rst_n),
    .restart       (restart),
    .minute_tick   (minute_tick),
    .accept        (accept),
    .acc_in_win    (acc_in_win),
    .tick_eval     (tick_eval),
    .tick_pass     (tick_pass),
    .tick_slope_ok (tick_slope_ok),
    .soak_min      (soak_min),
    .idle_lim      (idle_lim),
    .phase         (phase_st),
    .learn_en      (learn_en)
  );

  wq_ttw #(.TTW_W(TTW_W)) u_ttw (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (restart),
    .minute_tick (minute_tick),
    .acc_in_win  (acc_in_win),
    .ttw_minutes (ttw_minutes),
    .ttw_valid   (ttw_valid)
  );

  assign phase     = phase_st;
  assign qualified = (phase_st == PH_QUALIFIED);
endmodule

// File: rtl/wq_checker.sv
module wq_checker #(
  parameter int ERR_W = 16,
  parameter int TTW_W = 10
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    restart,
  input logic                    minute_tick,
  input logic                    smp_valid,
  input logic                    smp_ready,
  input logic signed [ERR_W-1:0] smp_err,
  input logic [ERR_W-1:0]        win_lim,
  input logic [1:0]              phase,
  input logic                    qualified,
  input logic                    ttw_valid,
  input logic [TTW_W-1:0]        ttw_minutes,
  input logic                    learn_en
);
  logic [ERR_W:0] err_abs;
  assign err_abs = smp_err[ERR_W-1] ? -{smp_err[ERR_W-1], smp_err} : {1'b0, smp_err};

  assert_restart_to_transient_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase == 2'd0) && !qualified && !ttw_valid);

  assert_no_phase_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) == 2'd0) |-> (phase != 2'd2));

  assert_qualify_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qualified) |-> $past(minute_tick));

  assert_learn_needs_qualified_R8: assert property (@(posedge clk) disable iff (!rst_n)
    learn_en |-> ($past(qualified) && $past(smp_valid && smp_ready)));

  assert_ttw_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ttw_valid && $past(ttw_valid)) |-> (ttw_minutes == $past(ttw_minutes)));

  assert_window_miss_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready && (err_abs > {1'b0, win_lim}) && (phase != 2'd0)) |=> !qualified);
endmodule

bind warmup_qualifier wq_checker #(.ERR_W(ERR_W), .TTW_W(TTW_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .restart     (restart),
  .minute_tick (minute_tick),
  .smp_valid   (smp_valid),
  .smp_ready   (smp_ready),
  .smp_err     (smp_err),
  .win_lim     (win_lim),
  .phase       (phase),
  .qualified   (qualified),
  .ttw_valid   (ttw_valid),
  .ttw_minutes (ttw_minutes),
  .learn_en    (learn_en)
);

// File: tb/warmup_qualifier_test.sv
module warmup_qualifier_test;
  localparam int CLK_PERIOD = 10;
  localparam int ERR_W = 16, TTW_W = 10, SOAK_W = 8, IDLE_W = 8;
  localparam int TTW_SAT = (1 << TTW_W) - 1;
  localparam int IDLE_SAT = (1 << IDLE_W) - 1;
  localparam int SOAK_SAT = (1 << SOAK_W) - 1;

  logic clk = 0, rst_n = 0, restart = 0, minute_tick = 0, smp_valid = 0;
  logic smp_ready, qualified, ttw_valid, learn_en;
  logic signed [ERR_W-1:0] smp_err = '0;
  logic [ERR_W-1:0] win_lim = 16'd50, rate_lim = 16'd20;
  logic [SOAK_W-1:0] soak_min = 8'd3;
  logic [IDLE_W-1:0] idle_lim = 8'd4;
  logic [1:0] phase;
  logic [TTW_W-1:0] ttw_minutes;

  warmup_qualifier #(.ERR_W(ERR_W), .TTW_W(TTW_W), .SOAK_W(SOAK_W), .IDLE_W(IDLE_W)) uut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .minute_tick(minute_tick),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_err(smp_err),
    .win_lim(win_lim), .rate_lim(rate_lim), .soak_min(soak_min), .idle_lim(idle_lim),
    .phase(phase), .qualified(qualified), .ttw_valid(ttw_valid),
    .ttw_minutes(ttw_minutes), .learn_en(learn_en));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  typedef struct packed {
    logic [1:0] ph; logic q; logic tv; logic [TTW_W-1:0] t; logic l;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  // reference state, from the requirements
  int m_phase, m_soak, m_idle, m_last, m_prev, m_elapsed, m_ttw;
  bit m_have, m_prevok, m_ttwv, m_learn;

  function automatic int iabs(int v); return (v < 0) ? -v : v; endfunction

  task automatic model(bit v, int e, bit t, bit r);
    bit acc, acc_in, slope_ok, tev, pass, starve;
    int cur, idle_inc;
    if (r) begin
      m_phase = 0; m_soak = 0; m_idle = 0; m_have = 0; m_prevok = 0;
      m_elapsed = 0; m_ttw = 0; m_ttwv = 0; m_learn = 0;
      return;
    end
    acc = v;
    acc_in = acc && (iabs(e) <= int'(win_lim));
    cur = acc ? e : m_last;
    slope_ok = m_prevok && (iabs(cur - m_prev) <= int'(rate_lim));
    tev = t && (m_have || acc);
    pass = (iabs(cur) <= int'(win_lim)) && slope_ok;
    idle_inc = (m_idle == IDLE_SAT) ? m_idle : m_idle + 1;
    starve = t && !acc && (idle_lim != 0) && (idle_inc >= int'(idle_lim));
    m_learn = acc_in && (m_phase == 2);
    if (m_phase == 0) begin
      if (tev && slope_ok) m_phase = 1;
    end else if ((acc && !acc_in) || starve) begin
      m_phase = 1; m_soak = 0;
    end else if (tev) begin
      if (pass) begin
        if (m_soak < SOAK_SAT) m_soak++;
        if (m_soak >= int'(soak_min)) m_phase = 2;
      end else begin
        m_phase = 1; m_soak = 0;
      end
    end
    if (acc) m_idle = 0; else if (t) m_idle = idle_inc;
    if (!m_ttwv && acc_in) begin m_ttw = m_elapsed; m_ttwv = 1; end
    if (t && m_elapsed < TTW_SAT) m_elapsed++;
    if (acc) begin m_last = e; m_have = 1; end
    if (tev) begin m_prev = cur; m_prevok = 1; end
  endtask

  task automatic check(string req, int act, int expv, string what);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected outputs
  task automatic step(bit v, int e, bit t, bit r);
    exp_t x;
    @(negedge clk);
    smp_valid = v; smp_err = ERR_W'(e); minute_tick = t; restart = r;
    #1 check("R2", int'(smp_ready), int'(!r), "smp_ready");
    @(posedge clk);
    model(v, e, t, r);
    x.ph = 2'(m_phase); x.q = (m_phase == 2); x.tv = m_ttwv;
    x.t = TTW_W'(m_ttw); x.l = m_learn;
    exp_q.push_back(x); tag_q.push_back(cur_req);
    #1 smp_valid = 0; minute_tick = 0; restart = 0;
  endtask

  // monitor: pops and compares at the falling edge
  initial begin
    exp_t x; string tg;
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        x = exp_q.pop_front(); tg = tag_q.pop_front();
        checks++;
        if (phase !== x.ph || qualified !== x.q || ttw_valid !== x.tv ||
            ttw_minutes !== x.t || learn_en !== x.l) begin
          errors++;
          $display("FAIL %s outputs: actual ph=%0d q=%0d tv=%0d ttw=%0d l=%0d expected ph=%0d q=%0d tv=%0d ttw=%0d l=%0d",
                   tg, phase, qualified, ttw_valid, ttw_minutes, learn_en,
                   x.ph, x.q, x.tv, x.t, x.l);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model(0, 0, 0, 1);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", phase, 0, "phase"); check("R1", qualified, 0, "qualified");
    check("R1", ttw_valid, 0, "ttw_valid"); check("R1", learn_en, 0, "learn_en");
    rst_n = 1;

    // R5 transient exit on a slow tick; R3 time-to-window
    cur_req = "R5";
    step(0, 0, 0, 1);
    step(1, 1000, 1, 0); step(1, 700, 1, 0); step(1, 400, 1, 0);
    check("R5", phase, 0, "phase still transient");
    step(1, 390, 1, 0);
    #1 check("R5", phase, 1, "phase settling");
    cur_req = "R3";
    step(1, 40, 0, 0);
    #1 check("R3", ttw_minutes, 4, "ttw_minutes"); check("R3", ttw_valid, 1, "ttw_valid");
    // R6 soak
    cur_req = "R6";
    step(1, 35, 1, 0); step(1, 30, 1, 0); step(1, 28, 1, 0);
    #1 check("R6", qualified, 0, "not yet qualified");
    step(1, 27, 1, 0);
    #1 check("R6", qualified, 1, "qualified after soak");
    // R8 learn enable
    cur_req = "R8";
    step(1, 29, 0, 0);
    #1 check("R8", learn_en, 1, "learn_en");
    step(0, 0, 0, 0);
    // R7 out-of-window sample
    cur_req = "R7";
    step(1, 80, 0, 0);
    #1 check("R7", qualified, 0, "dropped"); check("R7", ttw_minutes, 4, "ttw kept");
    step(1, -45, 0, 0);
    // requalify and break on a drift jump
    step(1, 10, 1, 0); step(1, 10, 1, 0); step(1, 10, 1, 0); step(1, 10, 1, 0);
    step(1, 45, 1, 0);
    #1 check("R7", phase, 1, "slope violation drops to settling");
    // R9 idle supervision
    cur_req = "R9";
    step(1, 45, 1, 0); step(1, 45, 1, 0); step(1, 45, 1, 0);
    #1 check("R9", qualified, 1, "qualified before idle");
    step(0, 0, 1, 0); step(0, 0, 1, 0); step(0, 0, 1, 0);
    #1 check("R9", qualified, 1, "still qualified at 3 empty ticks");
    step(0, 0, 1, 0);
    #1 check("R9", qualified, 0, "dropped at 4th empty tick");
    // R10 restart from qualified
    cur_req = "R10";
    step(1, 5, 1, 0); step(1, 5, 1, 0); step(1, 5, 1, 0);
    step(1, 5, 0, 1);
    #1 check("R10", phase, 0, "phase"); check("R10", ttw_valid, 0, "ttw_valid");
    step(1, 5, 1, 0);
    #1 check("R10", phase, 0, "no drift history after restart");
    // R11 full-scale opposite samples
    cur_req = "R11";
    win_lim = 16'hFFFF; rate_lim = 16'd100;
    step(0, 0, 0, 1);
    step(1, 32767, 1, 0); step(1, 32767, 1, 0); step(1, 32767, 1, 0);
    step(1, 32767, 1, 0); step(1, 32767, 1, 0);
    #1 check("R11", qualified, 1, "qualified at full scale");
    step(1, -32767, 1, 0);
    #1 check("R11", qualified, 0, "wide drift detected");
    step(1, -32768, 0, 0);
    // R4 saturation of the minute count
    cur_req = "R4";
    win_lim = 16'd50; rate_lim = 16'd20;
    step(0, 0, 0, 1);
    for (int i = 0; i < TTW_SAT + 8; i++) step(0, 0, 1, 0);
    step(1, 10, 0, 0);
    #1 check("R4", ttw_minutes, TTW_SAT, "saturated ttw");
    step(0, 0, 0, 0);
    @(negedge clk); @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule